// File: doc/BRIEF.md
# Configurable LIFO Stack Unit

This block is a hardware stack built on an internal register array. A stack pointer tracks the top of the stack. Each clock cycle accepts one push or one pop. Two static parameters select the pointer convention at elaboration:

- **Direction:** the pointer grows toward higher or toward lower addresses as items are pushed.
- **Full or empty:** the pointer either names the slot of the newest item or names the next free slot.

The choice of convention decides two things. It decides whether a push moves the pointer before or after writing. It decides whether a pop reads before or after moving the pointer.

Misuse is refused instead of corrupting the stack. A push into a full stack, a pop from an empty stack, or a push and a pop in the same cycle leaves the pointer and the stored data untouched. Each of these cases sets a sticky error flag. A pointer load port places the empty stack at any slot, so each software context can own its own region of the array. The load also clears the item count and all error flags. Popped data comes out of a register one cycle after the pop strobe, together with a valid strobe.

Top module: `lifo_stack`

## Requirements
- R1: Accepted pops return data in last-in, first-out order with respect to accepted pushes.
- R2: An accepted push moves `sp_o` by one entry: +1 when ASCEND=1 and -1 when ASCEND=0. An accepted pop moves it one entry the other way. All pointer arithmetic wraps modulo DEPTH.
- R3: With FULL_MODE=1, `sp_o` names the newest stored item. A push first steps the pointer, then writes. A pop reads at `sp_o`, then steps back. After reset, `sp_o` is DEPTH-1 when ASCEND=1 and 0 when ASCEND=0.
- R4: With FULL_MODE=0, `sp_o` names the next free slot. A push writes at `sp_o`, then steps. A pop steps back first, then reads. After reset, `sp_o` is 0 when ASCEND=1 and DEPTH-1 when ASCEND=0.
- R5: A push while DEPTH items are stored is refused. Pointer and stored data stay unchanged, and `ovf_o` rises and stays high until the next load.
- R6: A pop while no items are stored is refused. The pointer stays unchanged, `rvalid_o` stays low, and `unf_o` rises and stays high until the next load.
- R7: Push and pop asserted in the same cycle perform neither operation. `clash_o` rises and stays high until the next load.
- R8: A load sets `sp_o` to `load_sp_i` in the next cycle, empties the stack (item count 0), and clears `ovf_o`, `unf_o` and `clash_o`.
- R9: A load takes priority over a push or pop in the same cycle; the push or pop is dropped.
- R10: After an accepted pop, `rdata_o` holds the popped item and `rvalid_o` is high for exactly the following cycle. `rvalid_o` is low in every other cycle.
- R11: Reset clears the item count, all three error flags and `rvalid_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| wdata_i | input | DATA_W | Data to push |
| load_i | input | 1 | Pointer load strobe |
| load_sp_i | input | $clog2(DEPTH) | Pointer value to load |
| rdata_o | output | DATA_W | Registered pop data |
| rvalid_o | output | 1 | Pop data valid, one cycle after an accepted pop |
| sp_o | output | $clog2(DEPTH) | Current stack pointer |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| clash_o | output | 1 | Sticky flag for push and pop in the same cycle |

## Verification
A wrong item count shows up at the ports when the stack reaches a boundary. Either a legal pop is refused with `unf_o`, or an illegal push is accepted and `ovf_o` never rises. Both appear in the cycle after the offending strobe. A pointer step in the wrong direction, or a step that lands in the wrong order relative to the memory access, shows at `sp_o` one cycle after the push. It also shows at `rdata_o` one cycle after the pop that reads the wrongly placed item. The bench therefore drives every convention side by side through the same stimulus and compares pointer, flags and data after every cycle.

// File: rtl/stack_pkg.sv
`timescale 1ns/1ps
package stack_pkg;
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_PUSH  = 2'd1,
      ACT_POP   = 2'd2,
      ACT_CLASH = 2'd3
   } stack_act_e;
endpackage

// File: rtl/stack_guard.sv
`timescale 1ns/1ps
// Occupancy tracking and acceptance of requests; owns the sticky error flags.
module stack_guard
   import stack_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push_i,
   input  logic pop_i,
   input  logic load_i,
   output logic do_push,
   output logic do_pop,
   output logic ovf_o,
   output logic unf_o,
   output logic clash_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   logic [CNT_W-1:0] count_q;
   stack_act_e       act;
   logic             full_w, empty_w;

   assign full_w  = (count_q == CNT_MAX);
   assign empty_w = (count_q == '0);

   always_comb begin
      act = ACT_NONE;
      if (!load_i) begin
         if (push_i && pop_i)
            act = ACT_CLASH;
         else if (push_i)
            act = ACT_PUSH;
         else if (pop_i)
            act = ACT_POP;
      end
   end

   assign do_push = (act == ACT_PUSH) && !full_w;
   assign do_pop  = (act == ACT_POP)  && !empty_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         ovf_o   <= 1'b0;
         unf_o   <= 1'b0;
         clash_o <= 1'b0;
      end else if (load_i) begin
         count_q <= '0;
         ovf_o   <= 1'b0;
         unf_o   <= 1'b0;
         clash_o <= 1'b0;
      end else begin
         if (do_push)
            count_q <= count_q + 1'b1;
         else if (do_pop)
            count_q <= count_q - 1'b1;
         if (act == ACT_PUSH && full_w)
            ovf_o <= 1'b1;
         if (act == ACT_POP && empty_w)
            unf_o <= 1'b1;
         if (act == ACT_CLASH)
            clash_o <= 1'b1;
      end
   end
endmodule

// File: rtl/stack_ptr_unit.sv
`timescale 1ns/1ps
// Stack pointer with convention-specific pre/post update and access addresses.
module stack_ptr_unit #(
   parameter int DEPTH     = 8,
   parameter bit FULL_MODE = 1'b1,
   parameter bit ASCEND    = 1'b1,
   localparam int PTR_W    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [PTR_W-1:0] load_sp_i,
   input  logic             do_push,
   input  logic             do_pop,
   output logic [PTR_W-1:0] sp_q,
   output logic [PTR_W-1:0] wr_addr,
   output logic [PTR_W-1:0] rd_addr
);
   // Full+ascending and empty+descending start at the top slot, the others at 0.
   localparam logic [PTR_W-1:0] INIT_PTR =
      (FULL_MODE == ASCEND) ? PTR_W'(DEPTH - 1) : '0;

   logic [PTR_W-1:0] fwd, back;

   generate
      if (ASCEND) begin : g_up
         assign fwd  = sp_q + 1'b1;
         assign back = sp_q - 1'b1;
      end else begin : g_down
         assign fwd  = sp_q - 1'b1;
         assign back = sp_q + 1'b1;
      end

      if (FULL_MODE) begin : g_full
         assign wr_addr = fwd;   // pre-step, then write
         assign rd_addr = sp_q;  // read, then post-step
      end else begin : g_empty
         assign wr_addr = sp_q;  // write, then post-step
         assign rd_addr = back;  // pre-step, then read
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sp_q <= INIT_PTR;
      else if (load_i)
         sp_q <= load_sp_i;
      else if (do_push)
         sp_q <= fwd;
      else if (do_pop)
         sp_q <= back;
   end
endmodule

// File: rtl/stack_mem.sv
`timescale 1ns/1ps
// Register array with one write port and one registered read port.
module stack_mem #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PTR_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [PTR_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata_q,
   output logic              rvalid_q
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         cells[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= re;
         if (re)
            rdata_q <= cells[raddr];
      end
   end
endmodule

// File: rtl/lifo_stack.sv
`timescale 1ns/1ps
module lifo_stack #(
   parameter int DATA_W    = 16,
   parameter int DEPTH     = 8,
   parameter bit FULL_MODE = 1'b1,
   parameter bit ASCEND    = 1'b1,
   localparam int PTR_W    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              load_i,
   input  logic [PTR_W-1:0]  load_sp_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o,
   output logic [PTR_W-1:0]  sp_o,
   output logic              ovf_o,
   output logic              unf_o,
   output logic              clash_o
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("lifo_stack: DEPTH must be a power of two, at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("lifo_stack: DATA_W must be positive");
      end
   endgenerate

   logic             do_push, do_pop;
   logic [PTR_W-1:0] wr_addr, rd_addr;

   stack_guard #(.DEPTH(DEPTH)) u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push_i),
      .pop_i   (pop_i),
      .load_i  (load_i),
      .do_push (do_push),
      .do_pop  (do_pop),
      .ovf_o   (ovf_o),
      .unf_o   (unf_o),
      .clash_o (clash_o)
   );

   stack_ptr_unit #(
      .DEPTH     (DEPTH),
      .FULL_MODE (FULL_MODE),
      .ASCEND    (ASCEND)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load_i),
      .load_sp_i (load_sp_i),
      .do_push   (do_push),
      .do_pop    (do_pop),
      .sp_q      (sp_o),
      .wr_addr   (wr_addr),
      .rd_addr   (rd_addr)
   );

   stack_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (do_push),
      .waddr    (wr_addr),
      .wdata    (wdata_i),
      .re       (do_pop),
      .raddr    (rd_addr),
      .rdata_q  (rdata_o),
      .rvalid_q (rvalid_o)
   );
endmodule

// File: rtl/lifo_stack_chk.sv
`timescale 1ns/1ps
module lifo_stack_chk #(
   parameter int DEPTH  = 8,
   parameter bit ASCEND = 1'b1,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             push_i,
   input logic             pop_i,
   input logic             load_i,
   input logic [PTR_W-1:0] load_sp_i,
   input logic [PTR_W-1:0] sp_o,
   input logic             rvalid_o,
   input logic             ovf_o,
   input logic             unf_o,
   input logic             clash_o
);
   function automatic logic [PTR_W-1:0] step_fwd(input logic [PTR_W-1:0] p);
      return ASCEND ? p + 1'b1 : p - 1'b1;
   endfunction

   function automatic logic [PTR_W-1:0] step_back(input logic [PTR_W-1:0] p);
      return ASCEND ? p - 1'b1 : p + 1'b1;
   endfunction

   a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && !load_i) |=>
         (sp_o == step_fwd($past(sp_o))) || (ovf_o && $stable(sp_o)));

   a_r2_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && !load_i) |=>
         (sp_o == step_back($past(sp_o)) && rvalid_o) ||
         (unf_o && $stable(sp_o) && !rvalid_o));

   a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !load_i) |=> ovf_o);

   a_r6_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (unf_o && !load_i) |=> unf_o);

   a_r7_clash_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && !load_i) |=> (clash_o && $stable(sp_o) && !rvalid_o));

   a_r8_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (sp_o == $past(load_sp_i) && !ovf_o && !unf_o && !clash_o));

   a_r10_rvalid_source: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid_o |-> $past(pop_i && !push_i && !load_i));

   a_r11_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!rvalid_o && !ovf_o && !unf_o && !clash_o));
endmodule

bind lifo_stack lifo_stack_chk #(.DEPTH(DEPTH), .ASCEND(ASCEND)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .push_i    (push_i),
   .pop_i     (pop_i),
   .load_i    (load_i),
   .load_sp_i (load_sp_i),
   .sp_o      (sp_o),
   .rvalid_o  (rvalid_o),
   .ovf_o     (ovf_o),
   .unf_o     (unf_o),
   .clash_o   (clash_o)
);

// File: tb/lifo_stack_test.sv
`timescale 1ns/1ps
module lifo_stack_test;
   localparam int DW = 16;
   localparam int DP = 8;
   localparam int PW = 3;
   localparam int LANES = 4;   // 0 full/up, 1 full/down, 2 empty/up, 3 empty/down

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push = 1'b0, pop = 1'b0, load = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [PW-1:0] load_sp = '0;

   logic [DW-1:0] rd  [LANES];
   logic          rv  [LANES];
   logic [PW-1:0] sp  [LANES];
   logic          ov  [LANES];
   logic          un  [LANES];
   logic          cl  [LANES];

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // bench model
   int            esp [LANES];
   logic [DW-1:0] stk [DP];
   int            cnt = 0;
   bit            e_ov = 0, e_un = 0, e_cl = 0;

   always #2 clk = ~clk;

   for (genvar g = 0; g < LANES; g++) begin : gen_lane
      lifo_stack #(
         .DATA_W    (DW),
         .DEPTH     (DP),
         .FULL_MODE (g < 2),
         .ASCEND    (g % 2 == 0)
      ) uut (
         .clk       (clk),
         .rst_n     (rst_n),
         .push_i    (push),
         .pop_i     (pop),
         .wdata_i   (wdata),
         .load_i    (load),
         .load_sp_i (load_sp),
         .rdata_o   (rd[g]),
         .rvalid_o  (rv[g]),
         .sp_o      (sp[g]),
         .ovf_o     (ov[g]),
         .unf_o     (un[g]),
         .clash_o   (cl[g])
      );
   end

   function automatic bit lane_up(int g);
      return (g % 2) == 0;
   endfunction

   task automatic chk_eq(string req, string what, int g, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s lane%0d %s actual=%0d expected=%0d", req, g, what, act, exp);
      end
   endtask

   task automatic check_all(string req, bit popped, logic [DW-1:0] edata);
      for (int g = 0; g < LANES; g++) begin
         chk_eq(req, "sp", g, int'(sp[g]), esp[g]);
         chk_eq(req, "ovf", g, int'(ov[g]), int'(e_ov));
         chk_eq(req, "unf", g, int'(un[g]), int'(e_un));
         chk_eq(req, "clash", g, int'(cl[g]), int'(e_cl));
         chk_eq(req, "rvalid", g, int'(rv[g]), int'(popped));
         if (popped) chk_eq(req, "rdata", g, int'(rd[g]), int'(edata));
      end
   endtask

   // One clock of stimulus, model update, and check one cycle later.
   task automatic cyc(string req, bit pu, bit po, bit ld,
                      logic [DW-1:0] d, logic [PW-1:0] lv);
      bit            popped = 1'b0;
      logic [DW-1:0] ed = '0;
      @(negedge clk);
      push = pu; pop = po; load = ld; wdata = d; load_sp = lv;
      @(negedge clk);
      push = 0; pop = 0; load = 0;
      if (ld) begin
         for (int g = 0; g < LANES; g++) esp[g] = int'(lv);
         cnt = 0; e_ov = 0; e_un = 0; e_cl = 0;
      end else if (pu && po) begin
         e_cl = 1;
      end else if (pu) begin
         if (cnt == DP) e_ov = 1;
         else begin
            stk[cnt] = d; cnt++;
            for (int g = 0; g < LANES; g++)
               esp[g] = (esp[g] + (lane_up(g) ? 1 : DP - 1)) % DP;
         end
      end else if (po) begin
         if (cnt == 0) e_un = 1;
         else begin
            cnt--; ed = stk[cnt]; popped = 1;
            for (int g = 0; g < LANES; g++)
               esp[g] = (esp[g] + (lane_up(g) ? DP - 1 : 1)) % DP;
         end
      end
      check_all(req, popped, ed);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      esp[0] = DP - 1; esp[1] = 0; esp[2] = 0; esp[3] = DP - 1;
      @(negedge clk);
      for (int g = 0; g < LANES; g++)
         chk_eq(g < 2 ? "R3" : "R4", "reset sp", g, int'(sp[g]), esp[g]);
      check_all("R11", 1'b0, '0);
   endtask

   task automatic t_push_pop();
      cyc("R2", 1, 0, 0, 16'hA001, '0);
      cyc("R2", 1, 0, 0, 16'hA002, '0);
      cyc("R2", 1, 0, 0, 16'hA003, '0);
      cyc("R1", 0, 1, 0, '0, '0);
      cyc("R1", 0, 1, 0, '0, '0);
      cyc("R10", 0, 0, 0, '0, '0);   // rvalid drops after the pop cycle
      cyc("R1", 0, 1, 0, '0, '0);
   endtask

   task automatic t_underflow();
      cyc("R6", 0, 1, 0, '0, '0);          // empty pop refused
      cyc("R6", 1, 0, 0, 16'h0D01, '0);    // flag sticky across a push
      cyc("R6", 0, 1, 0, '0, '0);
      cyc("R8", 0, 0, 1, '0, 3'd5);        // load clears the flag
   endtask

   task automatic t_overflow();
      for (int i = 0; i < DP; i++)
         cyc("R5", 1, 0, 0, 16'hB000 + DW'(i), '0);
      cyc("R5", 1, 0, 0, 16'hBEEF, '0);    // refused, sp held
      cyc("R5", 0, 1, 0, '0, '0);          // top is still the last accepted item
   endtask

   task automatic t_clash();
      cyc("R7", 1, 1, 0, 16'hCAFE, '0);
      cyc("R7", 0, 1, 0, '0, '0);          // previous top unchanged
   endtask

   task automatic t_load_priority();
      cyc("R9", 1, 0, 1, 16'hCCCC, 3'd2);  // push dropped
      cyc("R9", 0, 1, 0, '0, '0);          // stack empty: underflow
      cyc("R8", 0, 0, 1, '0, 3'd6);
   endtask

   task automatic t_wrap();
      for (int i = 0; i < 4; i++)
         cyc("R2", 1, 0, 0, 16'hE100 + DW'(i), '0);
      for (int i = 0; i < 4; i++)
         cyc("R1", 0, 1, 0, '0, '0);
   endtask

   initial begin
      t_reset();
      t_push_pop();
      t_underflow();
      t_overflow();
      t_clash();
      t_load_priority();
      t_wrap();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule